// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block decides which of ten interrupt vectors the CPU should take next, and which level the CPU is currently serving. Each vector has one request line, already merged from its sources, and one priority-select bit. The arbiter grades every pending vector by level, picks one winner, and raises a request to the CPU together with that vector's entry address.

A small stack of in-service levels makes nesting follow the level rules. A CPU acknowledge pushes the granted level onto the stack. A return-from-interrupt strobe pops it. A new request goes to the CPU only when its level is strictly above the level now in service. A global enable masks every request without discarding any.

Top module: `irq_level_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `cpu_irq_o` is 0, `cur_level_o` is 0 (nothing in service) and `vec_addr_o` is 0x03.
- R2: Levels are encoded 0 none, 1 low, 2 high, 3 highest. Vectors 1 and 2 run at level 3 when their select bit is 1 and at level 1 when it is 0. Vectors 3 to 10 run at level 2 when their select bit is 1 and at level 1 when it is 0.
- R3: The address presented for vector n (vector n is request bit n-1) is 0x03 + 8*(n-1), giving 0x03 up to 0x4B.
- R4: When pending vectors sit at different levels, the one at the highest level is presented.
- R5: When several pending vectors share the best level, the lowest-numbered vector is presented.
- R6: `cpu_irq_o` rises on the clock edge after a request whose level is strictly above `cur_level_o`. With nothing in service, any level is accepted. A request at or below the level in service is held off.
- R7: An acknowledge while `cpu_irq_o` is 1 makes `cur_level_o` equal to the granted level, and makes `cpu_irq_o` 0, after the next edge.
- R8: A return strobe restores `cur_level_o` to the level that was in service before the latest acknowledge.
- R9: From the cycle `cpu_irq_o` rises until it is acknowledged, `cpu_irq_o` and `vec_addr_o` stay fixed, even if requests change or a better one arrives.
- R10: While `glob_en_i` is 0, no request reaches the CPU. Requests still held when it returns to 1 are presented one edge later.
- R11: An acknowledge and a return in the same cycle replace the top level in service with the granted level. The stack depth stays the same, so one later return empties it.
- R12: An acknowledge while `cpu_irq_o` is 0 has no effect. A return with nothing in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 10 | Request line per vector, bit n-1 for vector n |
| prio_sel_i | input | 10 | Priority select per vector (see R2) |
| glob_en_i | input | 1 | Global enable, 0 masks all requests |
| ack_i | input | 1 | CPU acknowledge strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |
| vec_addr_o | output | 8 | Entry address of the presented vector |
| cur_level_o | output | 2 | Level now in service (0 when none) |

## Verification
Acknowledge and return can land on the same edge. Both then act on the level stack at once: the pop must happen first and the push must reuse the freed slot. The bench provokes this by entering a low-level handler and raising a high-level request. It then drives both strobes in one cycle. It judges the result by `cur_level_o` reading 2 afterwards and by a single further return bringing it to 0. A second overlap, a new request arriving while a grant is held, is judged by the address staying unchanged until the acknowledge.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
// Package: shared level type and encodings for the interrupt arbiter.
// Assumes levels are ordered numerically, so a larger code is a higher level.
package irq_arb_pkg;
    localparam int LVL_W = 2;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_NONE = 2'd0;
    localparam lvl_t LVL_LOW  = 2'd1;
    localparam lvl_t LVL_HIGH = 2'd2;
    localparam lvl_t LVL_TOP  = 2'd3;
endpackage

// File: rtl/irq_level_map.sv
`timescale 1ns/1ps
// Module: irq_level_map
// Turns each request line and its select bit into an effective level.
// The first NUM_TOP vectors are promoted to the top level and the rest to
// the high level. A masked or idle line yields LVL_NONE.
// Assumes request lines are already synchronous to clk.
module irq_level_map
    import irq_arb_pkg::*;
#(
    parameter int NUM_VEC = 10,
    parameter int NUM_TOP = 2
) (
    input  logic [NUM_VEC-1:0]            req_i,
    input  logic [NUM_VEC-1:0]            sel_i,
    input  logic                          en_i,
    output logic [NUM_VEC-1:0][LVL_W-1:0] lvl_o
);
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        localparam lvl_t ELEV = (g < NUM_TOP) ? LVL_TOP : LVL_HIGH;
        // Grade one vector: masked or idle gives none, else low or elevated.
        always_comb begin
            if (req_i[g] && en_i)
                lvl_o[g] = sel_i[g] ? ELEV : LVL_LOW;
            else
                lvl_o[g] = LVL_NONE;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
// Module: irq_prio_pick
// Finds the highest level among the graded vectors. Ties go to the lowest
// index. Purely combinational; valid_o is 0 when no vector is graded.
module irq_prio_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_VEC = 10,
    localparam int IDX_W  = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0][LVL_W-1:0] lvl_i,
    output logic                          valid_o,
    output logic [IDX_W-1:0]              idx_o,
    output lvl_t                          lvl_o
);
    // Scan from the top index down so an equal level at a lower index wins.
    always_comb begin
        lvl_o = LVL_NONE;
        idx_o = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (lvl_i[i] != LVL_NONE && lvl_i[i] >= lvl_o) begin
                lvl_o = lvl_i[i];
                idx_o = IDX_W'(i);
            end
        end
        valid_o = (lvl_o != LVL_NONE);
    end
endmodule

// File: rtl/irq_level_stack.sv
`timescale 1ns/1ps
// Module: irq_level_stack
// LIFO of levels in service. A push and a pop in the same cycle replace the
// top entry. A pop on an empty stack and a push on a full one are dropped.
// top_o is LVL_NONE when empty.
module irq_level_stack
    import irq_arb_pkg::*;
#(
    parameter int DEPTH  = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  lvl_t             lvl_i,
    output lvl_t             top_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic [DEPTH-1:0][LVL_W-1:0] slot_q;
    logic [CNT_W-1:0]            cnt_q;
    logic [CNT_W-1:0]            wr_ptr;
    logic                        do_pop;
    logic                        do_push;

    // Qualify strobes against the fill level and choose the write slot.
    always_comb begin
        do_pop  = pop_i && (cnt_q != '0);
        do_push = push_i && (do_pop || cnt_q != CNT_W'(DEPTH));
        wr_ptr  = do_pop ? cnt_q - 1'b1 : cnt_q;
    end

    // Track the number of occupied slots.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (do_push && !do_pop)
            cnt_q <= cnt_q + 1'b1;
        else if (do_pop && !do_push)
            cnt_q <= cnt_q - 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Store a pushed level in its slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= LVL_NONE;
            else if (do_push && wr_ptr == CNT_W'(g))
                slot_q[g] <= lvl_i;
        end
    end

    // Read out the most recent entry.
    always_comb begin
        top_o = LVL_NONE;
        for (int i = 0; i < DEPTH; i++)
            if (cnt_q == CNT_W'(i + 1))
                top_o = slot_q[i];
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_level_arbiter.sv
`timescale 1ns/1ps
// Module: irq_level_arbiter (top)
// Grades requests, picks a winner, and raises cpu_irq_o when the winner
// outranks the level in service. The grant is held until the CPU
// acknowledges it. The acknowledge pushes the granted level and the return
// strobe pops it.
// Assumes: strobes are single-cycle, and request lines are synchronous.
module irq_level_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_VEC    = 10,
    parameter int NUM_TOP    = 2,
    parameter int DEPTH      = 3,
    parameter int VEC_W      = 8,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8,
    localparam int IDX_W     = $clog2(NUM_VEC),
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] req_i,
    input  logic [NUM_VEC-1:0] prio_sel_i,
    input  logic               glob_en_i,
    input  logic               ack_i,
    input  logic               reti_i,
    output logic               cpu_irq_o,
    output logic [VEC_W-1:0]   vec_addr_o,
    output logic [LVL_W-1:0]   cur_level_o
);
    logic [NUM_VEC-1:0][LVL_W-1:0] vec_lvl;
    logic                          best_vld;
    logic [IDX_W-1:0]              best_idx;
    lvl_t                          best_lvl;
    lvl_t                          top_lvl;
    logic [CNT_W-1:0]              stk_cnt;
    logic                          pend_q;
    logic [IDX_W-1:0]              pend_idx;
    lvl_t                          pend_lvl;
    logic                          accept;
    logic                          take;

    irq_level_map #(.NUM_VEC(NUM_VEC), .NUM_TOP(NUM_TOP)) u_map (
        .req_i (req_i),
        .sel_i (prio_sel_i),
        .en_i  (glob_en_i),
        .lvl_o (vec_lvl)
    );

    irq_prio_pick #(.NUM_VEC(NUM_VEC)) u_pick (
        .lvl_i   (vec_lvl),
        .valid_o (best_vld),
        .idx_o   (best_idx),
        .lvl_o   (best_lvl)
    );

    irq_level_stack #(.DEPTH(DEPTH)) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (take),
        .pop_i  (reti_i),
        .lvl_i  (pend_lvl),
        .top_o  (top_lvl),
        .cnt_o  (stk_cnt)
    );

    // Decide whether the winner may interrupt, and whether a grant is taken.
    always_comb begin
        accept = best_vld && (best_lvl > top_lvl);
        take   = ack_i && pend_q;
    end

    // Hold the grant until it is acknowledged, else re-arbitrate each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            pend_idx <= '0;
            pend_lvl <= LVL_NONE;
        end else if (take) begin
            pend_q   <= 1'b0;
        end else if (!pend_q) begin
            pend_q   <= accept;
            pend_idx <= best_idx;
            pend_lvl <= best_lvl;
        end
    end

    // Form the entry address of the held vector.
    always_comb begin
        vec_addr_o = VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(pend_idx);
    end

    assign cpu_irq_o   = pend_q;
    assign cur_level_o = top_lvl;
endmodule

// File: rtl/irq_level_arbiter_chk.sv
`timescale 1ns/1ps
// Module: irq_level_arbiter_chk
// Property checker bound into irq_level_arbiter. It watches the ports plus
// the held grant level and the stack fill count.
module irq_level_arbiter_chk
    import irq_arb_pkg::*;
#(
    parameter int NUM_TOP    = 2,
    parameter int DEPTH      = 3,
    parameter int VEC_W      = 8,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic             reti_i,
    input logic             cpu_irq_o,
    input logic [VEC_W-1:0] vec_addr_o,
    input lvl_t             cur_level_o,
    input lvl_t             pend_lvl,
    input logic [CNT_W-1:0] stk_cnt
);
    localparam logic [VEC_W-1:0] TOP_END = VEC_W'(VEC_BASE + VEC_STRIDE * NUM_TOP);

    AST_IRQ_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_o |-> (pend_lvl > cur_level_o)); // R6
    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_o && !ack_i) |=> (cpu_irq_o && $stable(vec_addr_o))); // R9
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_o && ack_i) |=> !cpu_irq_o); // R7
    AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_o && ack_i) |=> (cur_level_o == $past(pend_lvl))); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_o && ack_i && !reti_i) |-> (stk_cnt < CNT_W'(DEPTH))); // R7
    AST_RETI_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !(cpu_irq_o && ack_i) && stk_cnt != '0)
        |=> (stk_cnt == $past(stk_cnt) - 1'b1)); // R8
    AST_TOP_ONLY_LOW_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_o && pend_lvl == LVL_TOP) |-> (vec_addr_o < TOP_END)); // R2
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq_o |-> (vec_addr_o >= VEC_W'(VEC_BASE))); // R3
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
    .NUM_TOP(NUM_TOP), .DEPTH(DEPTH), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .reti_i      (reti_i),
    .cpu_irq_o   (cpu_irq_o),
    .vec_addr_o  (vec_addr_o),
    .cur_level_o (cur_level_o),
    .pend_lvl    (pend_lvl),
    .stk_cnt     (stk_cnt)
);

// File: tb/irq_level_arbiter_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario. Inputs change on the falling edge,
// and outputs are sampled on the falling edge after the edge that acts.
module irq_level_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] req_i;
    logic [9:0] prio_sel_i;
    logic       glob_en_i;
    logic       ack_i;
    logic       reti_i;
    logic       cpu_irq_o;
    logic [7:0] vec_addr_o;
    logic [1:0] cur_level_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_level_arbiter u_irq_level_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_sel_i(prio_sel_i),
        .glob_en_i(glob_en_i), .ack_i(ack_i), .reti_i(reti_i),
        .cpu_irq_o(cpu_irq_o), .vec_addr_o(vec_addr_o), .cur_level_o(cur_level_o)
    );

    function automatic int va(int n);
        return 3 + 8 * (n - 1);
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_i = '0; prio_sel_i = '0; glob_en_i = 1'b1;
        ack_i = 1'b0; reti_i = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic raise(int n, bit sel);
        req_i[n-1] = 1'b1;
        prio_sel_i[n-1] = sel;
    endtask

    task automatic ack_clear(int n);
        ack_i = 1'b1; req_i[n-1] = 1'b0;
        tick();
        ack_i = 1'b0;
    endtask

    task automatic do_reti();
        reti_i = 1'b1;
        tick();
        reti_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 irq", cpu_irq_o, 0);
        check("R1 level", cur_level_o, 0);
        check("R1 addr", vec_addr_o, 3);
    endtask

    task automatic t_single();
        do_reset();
        raise(5, 0);
        tick();
        check("R6 irq empty stack", cpu_irq_o, 1);
        check("R3 addr vec5", vec_addr_o, va(5));
        ack_clear(5);
        check("R7 level low", cur_level_o, 1);
        check("R7 irq drops", cpu_irq_o, 0);
        do_reti();
        check("R8 level restored", cur_level_o, 0);
        raise(10, 1);
        tick();
        check("R3 addr vec10", vec_addr_o, 8'h4B);
    endtask

    task automatic t_levels();
        do_reset();
        raise(4, 0); raise(8, 1);
        tick();
        check("R4 high beats low", vec_addr_o, va(8));
        do_reset();
        raise(2, 1); raise(3, 1);
        tick();
        check("R2 vec2 highest addr", vec_addr_o, va(2));
        ack_clear(2);
        check("R2 vec2 level 3", cur_level_o, 3);
        do_reset();
        raise(9, 1);
        tick();
        ack_clear(9);
        check("R2 vec9 level 2", cur_level_o, 2);
    endtask

    task automatic t_tie();
        do_reset();
        raise(7, 0); raise(3, 0);
        tick();
        check("R5 low tie", vec_addr_o, va(3));
        do_reset();
        raise(9, 1); raise(5, 1);
        tick();
        check("R5 high tie", vec_addr_o, va(5));
    endtask

    task automatic t_nesting();
        do_reset();
        raise(6, 0);
        tick();
        ack_clear(6);
        raise(7, 0);
        tick(2);
        check("R6 equal level blocked", cpu_irq_o, 0);
        raise(4, 1);
        tick();
        check("R6 higher accepted", cpu_irq_o, 1);
        check("R6 higher addr", vec_addr_o, va(4));
        ack_clear(4);
        check("R7 nested level", cur_level_o, 2);
        raise(1, 1);
        tick();
        check("R6 top over high", vec_addr_o, va(1));
        ack_clear(1);
        check("R7 level top", cur_level_o, 3);
        raise(2, 1);
        tick(2);
        check("R6 top blocked by top", cpu_irq_o, 0);
        req_i[1] = 1'b0;
        do_reti();
        check("R8 pop to high", cur_level_o, 2);
        do_reti();
        check("R8 pop to low", cur_level_o, 1);
        do_reti();
        check("R8 pop to none", cur_level_o, 0);
        tick();
        check("R6 blocked low now taken", vec_addr_o, va(7));
    endtask

    task automatic t_hold();
        do_reset();
        raise(8, 0);
        tick();
        raise(1, 1);
        tick();
        check("R9 addr held", vec_addr_o, va(8));
        req_i[7] = 1'b0;
        tick();
        check("R9 irq held", cpu_irq_o, 1);
        check("R9 addr still held", vec_addr_o, va(8));
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
        check("R9 held level pushed", cur_level_o, 1);
        tick();
        check("R9 better now presented", vec_addr_o, va(1));
    endtask

    task automatic t_enable();
        do_reset();
        glob_en_i = 1'b0;
        raise(3, 0);
        tick(3);
        check("R10 masked", cpu_irq_o, 0);
        glob_en_i = 1'b1;
        tick();
        check("R10 unmasked irq", cpu_irq_o, 1);
        check("R10 unmasked addr", vec_addr_o, va(3));
    endtask

    task automatic t_ack_reti();
        do_reset();
        raise(6, 0);
        tick();
        ack_clear(6);
        raise(4, 1);
        tick();
        check("R11 pending high", cpu_irq_o, 1);
        ack_i = 1'b1; reti_i = 1'b1; req_i[3] = 1'b0;
        tick();
        ack_i = 1'b0; reti_i = 1'b0;
        check("R11 top replaced", cur_level_o, 2);
        do_reti();
        check("R11 single pop empties", cur_level_o, 0);
    endtask

    task automatic t_ignore();
        do_reset();
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
        check("R12 stray ack level", cur_level_o, 0);
        do_reti();
        check("R12 empty reti level", cur_level_o, 0);
        raise(2, 0);
        tick();
        ack_clear(2);
        check("R12 stack intact after stray", cur_level_o, 1);
        do_reti();
        check("R12 back to none", cur_level_o, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_levels();
        t_tie();
        t_nesting();
        t_hold();
        t_enable();
        t_ack_reti();
        t_ignore();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule